// File: doc/BRIEF.md
# Card Data FIFO with Width Packing

This block buffers data between a processor bus and a byte-serial card data path. It holds two 32-byte FIFOs, one for each direction. The processor writes the transmit FIFO and reads the receive FIFO with accesses of one, two or four bytes. Each access is split into bytes, or built up from bytes, with the most significant byte of the access handled first.

A transfer starts when a total byte count and a direction are loaded. In the write direction, bytes leave the transmit FIFO towards the card. In the read direction, bytes from the card fill the receive FIFO. Each byte that moves reduces the remaining count by one. When the count reaches zero, the block stops moving data and emits completion pulses. The write direction adds a second completion pulse for programming.

The block does not keep interrupt request bits itself. It produces set and clear pulses for the service-request and completion bits, and a separate interrupt unit collects them. A flush command discards whatever is waiting in the transmit FIFO, so that software can refill it.

Top module: `cardDataPacker`

## Requirements
- R1: After reset, `xferActive`, `cardTxValid`, `cardRxReady`, `cpuRdValid` and all set pulses are low.
- R2: Each FIFO stores 32 bytes. A processor write that finds fewer free bytes than its width stores only the leading bytes that fit and drops the rest.
- R3: `cpuSize` selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. A write enters the transmit FIFO, and later reaches the card, starting with the most significant byte of the selected width (bits 31:24 for four bytes, 15:8 for two, 7:0 for one). Bits above the width are ignored.
- R4: A processor read removes up to width bytes from the receive FIFO and returns them on `cpuRdData` in the cycle after `cpuRdEn`, with `cpuRdValid` high. The first byte removed goes to the top lane of the width. Lanes with no byte, and bits above the width, read as zero.
- R5: In the write direction, `cardTxValid` is high only while the remaining count is non-zero and the transmit FIFO is not empty. Each accepted byte lowers the count by one. Bytes left in the FIFO after the count reaches zero are never presented.
- R6: In the read direction, `cardRxReady` is high only while the remaining count is non-zero and the receive FIFO holds fewer than 32 bytes. Each accepted byte lowers the count by one.
- R7: In a cycle where the transfer is active with a zero remaining count, `dataDoneSet` pulses for one cycle. `progDoneSet` pulses with it in the write direction only. `xferActive` is low from the next cycle.
- R8: `txReqSet` is high in every cycle of an active write-direction transfer with a non-zero count and no processor write. `txReqClr` is high in each processor write cycle.
- R9: `rxReqSet` is high in each cycle a byte is accepted from the card, unless a processor read occurs in the same cycle. `rxReqClr` is high in each processor read cycle.
- R10: A `flushPart` pulse empties the transmit FIFO and leaves the remaining count unchanged. Data written afterwards is what reaches the card.
- R11: `xferLoad` loads the count from `xferLen` and the direction from `xferWrite` (1 is write), starts the transfer and empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | Processor write to the transmit FIFO |
| cpuRdEn | input | 1 | Processor read from the receive FIFO |
| cpuSize | input | 2 | Access width code |
| cpuWrData | input | 32 | Processor write data |
| cpuRdData | output | 32 | Processor read data, registered |
| cpuRdValid | output | 1 | Read data valid, one cycle after the read |
| flushPart | input | 1 | Discard the transmit FIFO contents |
| xferLoad | input | 1 | Start a transfer |
| xferLen | input | 16 | Total transfer length in bytes |
| xferWrite | input | 1 | Direction: 1 sends to the card, 0 receives |
| xferActive | output | 1 | Transfer in progress |
| cardTxValid | output | 1 | Byte offered to the card |
| cardTxReady | input | 1 | Card accepts the offered byte |
| cardTxData | output | 8 | Byte to the card |
| cardRxValid | input | 1 | Card offers a byte |
| cardRxReady | output | 1 | Block accepts a card byte |
| cardRxData | input | 8 | Byte from the card |
| txReqSet | output | 1 | Set pulse for the transmit service request |
| txReqClr | output | 1 | Clear pulse for the transmit service request |
| rxReqSet | output | 1 | Set pulse for the receive service request |
| rxReqClr | output | 1 | Clear pulse for the receive service request |
| dataDoneSet | output | 1 | Set pulse for data-done status and interrupt |
| progDoneSet | output | 1 | Set pulse for program-done status and interrupt |

## Verification
The assertions check the following on every cycle:
- neither FIFO overflows or underflows through its multi-byte ports;
- a write to a full transmit FIFO changes nothing;
- an empty receive FIFO reads as zero;
- every card handshake lowers the count by exactly one;
- the card offer and card acceptance are never active together;
- the set and clear pulses of a request never coincide;
- a completion pulse is always followed by an idle transfer.

Only the bench scenarios can show the byte order that results from mixed access widths, and the partial store at the boundary of a full FIFO. The same holds for the lane placement of short reads, the extra byte stranded when the count runs out, the data that survives a flush, and the emptying of the receive FIFO by a new load.

// File: rtl/cardPackPkg.sv
package cardPackPkg;
  // Strobes from the control unit to the FIFO datapath
  typedef struct packed {
    logic clearAll;  // new transfer loaded: empty both FIFOs
    logic flushTx;   // discard transmit contents
    logic txPop;     // card took one byte from the transmit FIFO
    logic rxPush;    // card delivered one byte to the receive FIFO
  } fifoStrobeT;
endpackage

// File: rtl/bytePackFifo.sv
// Byte FIFO with up to LANES bytes pushed and popped per cycle.
// DEPTH must be a power of two so the pointers wrap naturally.
module bytePackFifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1,
  localparam int CW = $clog2(LANES) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic [CW-1:0]         pushCnt,
  input  logic [LANES-1:0][7:0] pushBytes,
  input  logic [CW-1:0]         popCnt,
  output logic [LANES-1:0][7:0] popBytes,
  output logic [LW-1:0]         level
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(pushCnt);
      rdPtr <= rdPtr + PW'(popCnt);
      level <= level + LW'(pushCnt) - LW'(popCnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int i = 0; i < LANES; i++) begin
        if (CW'(i) < pushCnt) mem[wrPtr + PW'(i)] <= pushBytes[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) popBytes[i] = mem[rdPtr + PW'(i)];
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clear |-> (LW'(pushCnt) <= LW'(DEPTH) - level));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    LW'(popCnt) <= level);
  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));
endmodule

// File: rtl/cardPackData.sv
// FIFO datapath: width packing of processor accesses into byte FIFOs.
module cardPackData
  import cardPackPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int BUSW = 8 * LANES,
  localparam int SW = $clog2(LANES),
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int CW = $clog2(LANES) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  fifoStrobeT      strb,
  input  logic            cpuWrEn,
  input  logic            cpuRdEn,
  input  logic [SW-1:0]   cpuSize,
  input  logic [BUSW-1:0] cpuWrData,
  output logic [BUSW-1:0] cpuRdData,
  output logic            cpuRdValid,
  output logic [7:0]      cardTxData,
  input  logic [7:0]      cardRxData,
  output logic [LW-1:0]   txLevel,
  output logic [LW-1:0]   rxLevel
);
  logic [CW-1:0]         nBytes;
  logic [LW-1:0]         txFree;
  logic [CW-1:0]         txPushCnt;
  logic [CW-1:0]         txPopCnt;
  logic [CW-1:0]         rxPushCnt;
  logic [CW-1:0]         rxPopCnt;
  logic [LANES-1:0][7:0] txPushBytes;
  logic [LANES-1:0][7:0] txPopBytes;
  logic [LANES-1:0][7:0] rxPushBytes;
  logic [LANES-1:0][7:0] rxPopBytes;
  logic [BUSW-1:0]       rdNext;

  // access width in bytes, codes at or above log2(LANES) select the full bus
  always_comb begin
    if (cpuSize >= SW'(SW)) nBytes = CW'(LANES);
    else                    nBytes = CW'(1) << cpuSize;
  end

  // transmit side: split the write, most significant byte first
  always_comb begin
    txFree = LW'(DEPTH) - txLevel;
    if (!cpuWrEn)                     txPushCnt = '0;
    else if (LW'(nBytes) <= txFree)   txPushCnt = nBytes;
    else                              txPushCnt = CW'(txFree);
    txPushBytes = '0;
    for (int i = 0; i < LANES; i++) begin
      int lane;
      lane = int'(nBytes) - 1 - i;
      if (CW'(i) < nBytes) txPushBytes[i] = cpuWrData[8*lane +: 8];
    end
    txPopCnt = strb.txPop ? CW'(1) : '0;
  end

  // receive side: first byte popped lands in the top lane of the width
  always_comb begin
    if (!cpuRdEn)                     rxPopCnt = '0;
    else if (LW'(nBytes) <= rxLevel)  rxPopCnt = nBytes;
    else                              rxPopCnt = CW'(rxLevel);
    rdNext = '0;
    for (int i = 0; i < LANES; i++) begin
      int lane;
      lane = int'(nBytes) - 1 - i;
      if (CW'(i) < rxPopCnt) rdNext[8*lane +: 8] = rxPopBytes[i];
    end
    rxPushCnt      = strb.rxPush ? CW'(1) : '0;
    rxPushBytes    = '0;
    rxPushBytes[0] = cardRxData;
  end

  bytePackFifo #(.DEPTH(DEPTH), .LANES(LANES)) txFifo (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (strb.clearAll | strb.flushTx),
    .pushCnt   (txPushCnt),
    .pushBytes (txPushBytes),
    .popCnt    (txPopCnt),
    .popBytes  (txPopBytes),
    .level     (txLevel)
  );

  bytePackFifo #(.DEPTH(DEPTH), .LANES(LANES)) rxFifo (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (strb.clearAll),
    .pushCnt   (rxPushCnt),
    .pushBytes (rxPushBytes),
    .popCnt    (rxPopCnt),
    .popBytes  (rxPopBytes),
    .level     (rxLevel)
  );

  assign cardTxData = txPopBytes[0];

  logic unusedTxLanes;
  assign unusedTxLanes = ^txPopBytes[LANES-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdData  <= '0;
      cpuRdValid <= 1'b0;
    end else begin
      cpuRdValid <= cpuRdEn;
      if (cpuRdEn) cpuRdData <= rdNext;
    end
  end

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && txLevel == LW'(DEPTH) && !strb.clearAll && !strb.flushTx && !strb.txPop)
      |=> txLevel == LW'(DEPTH));
  // R4
  rd_zero_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && rxLevel == '0) |=> cpuRdData == '0);
endmodule

// File: rtl/cardPackCtrl.sv
// Transfer control: remaining count, direction, card handshakes, pulses.
module cardPackCtrl
  import cardPackPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNTW = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            xferLoad,
  input  logic [CNTW-1:0] xferLen,
  input  logic            xferWrite,
  input  logic            flushPart,
  input  logic            cpuWrEn,
  input  logic            cpuRdEn,
  input  logic [LW-1:0]   txLevel,
  input  logic [LW-1:0]   rxLevel,
  output logic            cardTxValid,
  input  logic            cardTxReady,
  input  logic            cardRxValid,
  output logic            cardRxReady,
  output logic            xferActive,
  output fifoStrobeT      strb,
  output logic            txReqSet,
  output logic            txReqClr,
  output logic            rxReqSet,
  output logic            rxReqClr,
  output logic            dataDoneSet,
  output logic            progDoneSet
);
  logic [CNTW-1:0] remain;
  logic            active;
  logic            dirWrite;
  logic            haveRemain;
  logic            txMove;
  logic            rxMove;
  logic            finish;

  always_comb begin
    haveRemain  = (remain != '0);
    cardTxValid = active && dirWrite && haveRemain && (txLevel != '0) && !flushPart && !xferLoad;
    cardRxReady = active && !dirWrite && haveRemain && (rxLevel != LW'(DEPTH)) && !xferLoad;
    txMove      = cardTxValid && cardTxReady;
    rxMove      = cardRxReady && cardRxValid;
    finish      = active && !haveRemain && !xferLoad;

    strb.clearAll = xferLoad;
    strb.flushTx  = flushPart;
    strb.txPop    = txMove;
    strb.rxPush   = rxMove;

    dataDoneSet = finish;
    progDoneSet = finish && dirWrite;
    txReqClr    = cpuWrEn;
    txReqSet    = active && dirWrite && haveRemain && !cpuWrEn;
    rxReqClr    = cpuRdEn;
    rxReqSet    = rxMove && !cpuRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain   <= '0;
      active   <= 1'b0;
      dirWrite <= 1'b0;
    end else if (xferLoad) begin
      remain   <= xferLen;
      active   <= 1'b1;
      dirWrite <= xferWrite;
    end else if (finish) begin
      active <= 1'b0;
    end else if (txMove || rxMove) begin
      remain <= remain - CNTW'(1);
    end
  end

  assign xferActive = active;

  // R5 R6
  byte_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMove || rxMove) |=> remain == $past(remain) - CNTW'(1));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDoneSet |=> !xferActive);
  // R6
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cardTxValid && cardRxReady));
  // R8 R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txReqSet && txReqClr) && !(rxReqSet && rxReqClr));
endmodule

// File: rtl/cardDataPacker.sv
// Thin top: control unit drives the FIFO datapath through a strobe struct.
module cardDataPacker
  import cardPackPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int CNTW = 16,
  localparam int BUSW = 8 * LANES,
  localparam int SW = $clog2(LANES),
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuWrEn,
  input  logic            cpuRdEn,
  input  logic [SW-1:0]   cpuSize,
  input  logic [BUSW-1:0] cpuWrData,
  output logic [BUSW-1:0] cpuRdData,
  output logic            cpuRdValid,
  input  logic            flushPart,
  input  logic            xferLoad,
  input  logic [CNTW-1:0] xferLen,
  input  logic            xferWrite,
  output logic            xferActive,
  output logic            cardTxValid,
  input  logic            cardTxReady,
  output logic [7:0]      cardTxData,
  input  logic            cardRxValid,
  output logic            cardRxReady,
  input  logic [7:0]      cardRxData,
  output logic            txReqSet,
  output logic            txReqClr,
  output logic            rxReqSet,
  output logic            rxReqClr,
  output logic            dataDoneSet,
  output logic            progDoneSet
);
  fifoStrobeT    strb;
  logic [LW-1:0] txLevel;
  logic [LW-1:0] rxLevel;

  cardPackCtrl #(.DEPTH(DEPTH), .CNTW(CNTW)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .xferLoad    (xferLoad),
    .xferLen     (xferLen),
    .xferWrite   (xferWrite),
    .flushPart   (flushPart),
    .cpuWrEn     (cpuWrEn),
    .cpuRdEn     (cpuRdEn),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .cardTxValid (cardTxValid),
    .cardTxReady (cardTxReady),
    .cardRxValid (cardRxValid),
    .cardRxReady (cardRxReady),
    .xferActive  (xferActive),
    .strb        (strb),
    .txReqSet    (txReqSet),
    .txReqClr    (txReqClr),
    .rxReqSet    (rxReqSet),
    .rxReqClr    (rxReqClr),
    .dataDoneSet (dataDoneSet),
    .progDoneSet (progDoneSet)
  );

  cardPackData #(.DEPTH(DEPTH), .LANES(LANES)) data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuWrEn    (cpuWrEn),
    .cpuRdEn    (cpuRdEn),
    .cpuSize    (cpuSize),
    .cpuWrData  (cpuWrData),
    .cpuRdData  (cpuRdData),
    .cpuRdValid (cpuRdValid),
    .cardTxData (cardTxData),
    .cardRxData (cardRxData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel)
  );
endmodule

// File: tb/test_cardDataPacker.sv
module test_cardDataPacker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic        cpuRdEn = 1'b0;
  logic [1:0]  cpuSize = '0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic        cpuRdValid;
  logic        flushPart = 1'b0;
  logic        xferLoad = 1'b0;
  logic [15:0] xferLen = '0;
  logic        xferWrite = 1'b0;
  logic        xferActive;
  logic        cardTxValid;
  logic        cardTxReady = 1'b0;
  logic [7:0]  cardTxData;
  logic        cardRxValid = 1'b0;
  logic        cardRxReady;
  logic [7:0]  cardRxData = '0;
  logic        txReqSet, txReqClr, rxReqSet, rxReqClr, dataDoneSet, progDoneSet;

  always #2 clk = ~clk;  // 250 MHz

  cardDataPacker i_cardDataPacker (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuSize(cpuSize),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid),
    .flushPart(flushPart), .xferLoad(xferLoad), .xferLen(xferLen), .xferWrite(xferWrite),
    .xferActive(xferActive), .cardTxValid(cardTxValid), .cardTxReady(cardTxReady),
    .cardTxData(cardTxData), .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
    .cardRxData(cardRxData), .txReqSet(txReqSet), .txReqClr(txReqClr),
    .rxReqSet(rxReqSet), .rxReqClr(rxReqClr), .dataDoneSet(dataDoneSet),
    .progDoneSet(progDoneSet)
  );

  int compared = 0;
  int mismatched = 0;
  logic [7:0]  txExp[$];   // bytes expected at the card, in order
  logic [7:0]  rxModel[$]; // bytes held in the receive FIFO
  logic [31:0] rdExp[$];   // expected processor read results

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // monitor: card bytes and processor read results against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (cardTxValid && cardTxReady) begin
        if (txExp.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R3 unexpected card byte: actual %h expected none", cardTxData);
        end else begin
          chk("R3 card byte order", {24'h0, cardTxData}, {24'h0, txExp.pop_front()});
        end
      end
      if (cpuRdValid) begin
        if (rdExp.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R4 unexpected read data: actual %h expected none", cpuRdData);
        end else begin
          chk("R4 read lane packing", cpuRdData, rdExp.pop_front());
        end
      end
    end
  end

  function automatic int widthOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic loadXfer(input logic [15:0] len, input logic wr);
    xferLoad = 1'b1; xferLen = len; xferWrite = wr;
    txExp.delete();
    rxModel.delete();
    @(posedge clk); #1;
    xferLoad = 1'b0;
  endtask

  task automatic cpuWrite(input logic [1:0] sz, input logic [31:0] d);
    int n = widthOf(sz);
    int free = 32 - txExp.size();
    int take = (n < free) ? n : free;
    cpuWrEn = 1'b1; cpuSize = sz; cpuWrData = d;
    for (int i = 0; i < take; i++) txExp.push_back(d[8*(n-1-i) +: 8]);
    @(negedge clk);
    chk("R8 tx request clear on write", {31'h0, txReqClr}, 32'd1);
    chk("R8 no tx set during write", {31'h0, txReqSet}, 32'd0);
    @(posedge clk); #1;
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] sz);
    int n = widthOf(sz);
    int k = (n < rxModel.size()) ? n : rxModel.size();
    logic [31:0] e = '0;
    for (int i = 0; i < k; i++) e[8*(n-1-i) +: 8] = rxModel.pop_front();
    rdExp.push_back(e);
    cpuRdEn = 1'b1; cpuSize = sz;
    @(negedge clk);
    chk("R9 rx request clear on read", {31'h0, rxReqClr}, 32'd1);
    @(posedge clk); #1;
    cpuRdEn = 1'b0;
  endtask

  task automatic cardSend(input logic [7:0] b);
    int g = 0;
    cardRxValid = 1'b1; cardRxData = b;
    @(negedge clk);
    while (!cardRxReady && g < 100) begin g++; @(negedge clk); end
    chk("R9 rx request set on card byte", {31'h0, rxReqSet}, 32'd1);
    rxModel.push_back(b);
    @(posedge clk); #1;
    cardRxValid = 1'b0;
  endtask

  task automatic waitDone(input logic expProg);
    int g = 0;
    @(negedge clk);
    while (!dataDoneSet && g < 200) begin g++; @(negedge clk); end
    chk("R7 data done pulse", {31'h0, dataDoneSet}, 32'd1);
    chk("R7 program done by direction", {31'h0, progDoneSet}, {31'h0, expProg});
    chk("R5 no card offer at zero count", {31'h0, cardTxValid}, 32'd0);
    @(negedge clk);
    chk("R7 inactive after done", {31'h0, xferActive}, 32'd0);
    chk("R7 done is a single pulse", {31'h0, dataDoneSet}, 32'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset inactive", {31'h0, xferActive}, 32'd0);
    chk("R1 reset no card offer", {31'h0, cardTxValid}, 32'd0);
    chk("R1 reset no card accept", {31'h0, cardRxReady}, 32'd0);
    chk("R1 reset no done pulse", {31'h0, dataDoneSet}, 32'd0);
    chk("R1 reset no read valid", {31'h0, cpuRdValid}, 32'd0);
    chk("R1 reset no tx request", {31'h0, txReqSet}, 32'd0);
    @(posedge clk); #1;

    // mixed widths, write direction, count shorter than data (R3 R5 R8 R11)
    loadXfer(16'd7, 1'b1);
    @(negedge clk);
    chk("R8 tx request while bytes remain", {31'h0, txReqSet}, 32'd1);
    chk("R5 no offer from empty fifo", {31'h0, cardTxValid}, 32'd0);
    chk("R11 load makes active", {31'h0, xferActive}, 32'd1);
    @(posedge clk); #1;
    cpuWrite(2'd2, 32'hA1B2C3D4);
    cpuWrite(2'd1, 32'hFFFF1122);
    cpuWrite(2'd0, 32'hFFFFFF33);
    cpuWrite(2'd0, 32'h00000044);
    cardTxReady = 1'b1;
    waitDone(1'b1);
    cardTxReady = 1'b0;
    chk("R5 extra byte held back", txExp.size(), 32'd1);

    // fill to full with a partial store, then flush (R2 R3 R5 R10)
    loadXfer(16'd40, 1'b1);
    for (int w = 0; w < 7; w++)
      cpuWrite((w == 3) ? 2'd3 : 2'd2, 32'h01020304 + w * 32'h04040404);
    cpuWrite(2'd1, 32'h00001D1E);
    cpuWrite(2'd2, 32'h0A0B0C0D);
    cpuWrite(2'd0, 32'h00000055);
    cardTxReady = 1'b1;
    begin
      int g = 0;
      while (txExp.size() > 0 && g < 200) begin g++; @(negedge clk); end
    end
    @(negedge clk);
    chk("R5 stall on empty fifo with bytes remaining", {31'h0, cardTxValid}, 32'd0);
    chk("R5 still active with 8 remaining", {31'h0, xferActive}, 32'd1);
    @(posedge clk); #1;
    cardTxReady = 1'b0;
    cpuWrite(2'd2, 32'hDEADBEEF);
    flushPart = 1'b1;
    txExp.delete();
    @(negedge clk);
    chk("R8 tx request during flush", {31'h0, txReqSet}, 32'd1);
    @(posedge clk); #1;
    flushPart = 1'b0;
    @(negedge clk);
    chk("R10 flush empties transmit fifo", {31'h0, cardTxValid}, 32'd0);
    chk("R10 flush keeps transfer active", {31'h0, xferActive}, 32'd1);
    @(posedge clk); #1;
    cpuWrite(2'd2, 32'h61626364);
    cpuWrite(2'd2, 32'h65666768);
    cardTxReady = 1'b1;
    waitDone(1'b1);
    cardTxReady = 1'b0;
    chk("R10 refilled data all sent", txExp.size(), 32'd0);

    // read direction with short and partial reads (R4 R6 R7 R9)
    loadXfer(16'd6, 1'b0);
    @(negedge clk);
    chk("R6 ready for card bytes", {31'h0, cardRxReady}, 32'd1);
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) cardSend(8'h10 + 8'(i));
    waitDone(1'b0);
    cpuRead(2'd0);
    cpuRead(2'd1);
    cpuRead(2'd2);

    // receive fifo full, then reload empties it (R6 R11)
    loadXfer(16'd40, 1'b0);
    for (int i = 0; i < 32; i++) cardSend(8'h40 + 8'(i));
    cardRxValid = 1'b1; cardRxData = 8'hEE;
    @(negedge clk);
    chk("R6 not ready when receive fifo full", {31'h0, cardRxReady}, 32'd0);
    chk("R6 still active when full", {31'h0, xferActive}, 32'd1);
    @(posedge clk); #1;
    cardRxValid = 1'b0;
    cpuRead(2'd2);
    @(negedge clk);
    chk("R6 ready again after read", {31'h0, cardRxReady}, 32'd1);
    @(posedge clk); #1;
    loadXfer(16'd3, 1'b0);
    cpuRead(2'd2);  // R11 fifo emptied by load, reads zero

    repeat (3) @(posedge clk);
    chk("R4 every read returned", rdExp.size(), 32'd0);
    summary();
    $finish;
  end
endmodule